// File: doc/BRIEF.md
# Sampling ADC Conversion Controller

This block runs an external 8-bit serial sampling converter from a synchronous system clock. The converter has one pin that does two jobs: a falling edge on it freezes the analog input and starts a conversion, and the level on that pin shortly after the conversion ends tells the converter whether to power down. The controller produces that pin, waits out the conversion time, holds the level that selects power-down or stay-awake through the sampling point, and then sends a burst of serial clocks. It shifts in the returned word, checks it against the converter's active-low frame-sync line, and delivers it as a one-cycle valid pulse with the data.

All analog delays are parameters in nanoseconds. Each one is converted into a whole number of system clock cycles, rounded up. A `start` pulse requests one conversion. Holding `continuous` high repeats conversions, one every `period_cycles` clocks, but never faster than the conversion, readout and track/hold acquisition allow. The sequencer is a single state machine with six states. IDLE waits for a request. HOLD drives the pin low for the start pulse. CONVERT waits out the conversion while driving the chosen power level. PDSAMPLE keeps that level through the converter's sampling point. READ toggles the serial clock and captures the data bits. ACQUIRE waits out the acquisition time and the programmed period. The transitions are: IDLE to HOLD on `start` or `continuous`. HOLD to CONVERT when the pulse width is reached. CONVERT to PDSAMPLE at the end of conversion. PDSAMPLE to READ after the sampling delay. READ to ACQUIRE after the last clock pulse. ACQUIRE goes to HOLD if `continuous` is high, otherwise to IDLE, once both the period and the acquisition time have elapsed.

The numbers below use the default parameters at a 10 ns clock. The pulse is 2 cycles, the conversion 42, the power-down sampling delay 10, acquisition 20, and the serial clock half period 1 cycle. "Cycle n" counts from the first clock in which `cnv_n` is low, which is cycle 0.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, `cnv_n` is high, `sclk` is low and `result_valid` is low.
- R2: A `start` seen in IDLE drives `cnv_n` low in the next cycle, and it stays low for the pulse width: cycles 0 and 1.
- R3: `sclk` stays low for the whole conversion time, cycles 0 to 41, so no readout clock is sent before the conversion is done.
- R4: From cycle 2 through cycle 51, which is the end of the power-down sampling point, `cnv_n` equals the inverse of `power_down_req` as sampled in the clock before cycle 0. A 1 on `power_down_req` therefore holds the pin low, which means power down.
- R5: From cycle 52 until the next falling edge, `cnv_n` is high, so a converter that was powered down can wake before the next conversion.
- R6: The read burst has exactly 8 `sclk` pulses. Each is high for the half period and then low for the half period, and the first rising edge is at cycle 52. The converter changes `sdata` on the rising edge. The controller samples `sdata` at the clock edge on which `sclk` falls. The first bit is bit 7, the most significant bit.
- R7: `result_valid` is high for exactly one cycle, cycle 68, and `result_data` then carries the 8-bit word. `result_data` keeps that value afterwards.
- R8: If `frame_n` is high at any of the 8 capture edges, that conversion raises no `result_valid` and `result_data` keeps its previous value.
- R9: A `start` that arrives while a conversion is in progress is ignored and causes no extra conversion.
- R10: With `continuous` high, the gap between falling edges of `cnv_n` is the largest of three values: `period_cycles` as sampled at the earlier falling edge, the conversion plus acquisition time (62), and the end of readout plus one (69).
- R11: When `continuous` is cleared, the conversion in progress finishes and delivers its result. The controller then goes to IDLE with `cnv_n` high and starts no new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion (honoured only in IDLE) |
| continuous | input | 1 | Repeat conversions at the programmed period while high |
| power_down_req | input | 1 | 1 selects power-down after this conversion, 0 keeps the converter awake |
| period_cycles | input | CNT_W | Requested gap between conversions, in clock cycles |
| cnv_n | output | 1 | Combined convert-start and power-select pin to the converter |
| sclk | output | 1 | Serial readout clock to the converter, idles low |
| sdata | input | 1 | Serial data from the converter |
| frame_n | input | 1 | Active-low frame sync from the converter |
| result_valid | output | 1 | One-cycle pulse when a new word is available |
| result_data | output | DATA_W | Last captured word |

## Verification
Every result has a fixed cycle position, counted from the first cycle in which `cnv_n` is low. The power level must be right at cycle 51, the wake level from cycle 52, the first serial clock rising edge at 52, the valid pulse at 68, and it must be gone at 69. In continuous mode, falling edges are due exactly the R10 maximum apart. The bench keeps a per-conversion cycle counter that it samples on the falling clock edge, and checks each output at exactly those counts. A behavioural converter model supplies a known word for every conversion, and a sweep of 256 back-to-back conversions covers every data value while toggling the power choice.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_CONVERT,
        ST_PDSAMPLE,
        ST_READ,
        ST_ACQUIRE
    } seq_state_t;

    // whole clock cycles covering a delay, rounded up
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] elapsed
);
    // cycles since the last restart, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (restart) begin
            elapsed <= '0;
        end else if (elapsed != '1) begin
            elapsed <= elapsed + CNT_W'(1);
        end
    end
endmodule

// File: rtl/adc_serial_capture.sv
module adc_serial_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              strobe,
    input  logic              sdata,
    input  logic              frame_n,
    output logic [DATA_W-1:0] word,
    output logic              frame_ok
);
    // MSB arrives first: shift toward the top
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word     <= '0;
            frame_ok <= 1'b0;
        end else if (clear) begin
            frame_ok <= 1'b1;
        end else if (strobe) begin
            word     <= {word[DATA_W-2:0], sdata};
            frame_ok <= frame_ok & ~frame_n;
        end
    end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int CNT_W        = 16,
    parameter int CLK_NS       = 10,
    parameter int T_CNV_LOW_NS = 20,
    parameter int T_CONV_NS    = 420,
    parameter int T_PDS_NS     = 100,
    parameter int T_ACQ_NS     = 200,
    parameter int SCLK_HALF    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              continuous,
    input  logic              power_down_req,
    input  logic [CNT_W-1:0]  period_cycles,
    output logic              cnv_n,
    output logic              sclk,
    input  logic              sdata,
    input  logic              frame_n,
    output logic              result_valid,
    output logic [DATA_W-1:0] result_data
);
    localparam int LOW_CYC    = ns_to_cyc(T_CNV_LOW_NS, CLK_NS);
    localparam int CONV_CYC   = ns_to_cyc(T_CONV_NS, CLK_NS);
    localparam int PDS_CYC    = ns_to_cyc(T_PDS_NS, CLK_NS);
    localparam int ACQ_CYC    = ns_to_cyc(T_ACQ_NS, CLK_NS);
    localparam int READ_CYC   = 2 * DATA_W * SCLK_HALF;
    localparam int READ_START = CONV_CYC + PDS_CYC;
    localparam int ACQ_SPAN   = CONV_CYC + ACQ_CYC;

    localparam logic [CNT_W-1:0] LOW_END   = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_END  = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] PDS_END   = CNT_W'(READ_START - 1);
    localparam logic [CNT_W-1:0] READ_END  = CNT_W'(READ_START + READ_CYC - 1);
    localparam logic [CNT_W-1:0] READ_BASE = CNT_W'(READ_START);
    localparam logic [CNT_W-1:0] SPAN_MIN  = CNT_W'(ACQ_SPAN);
    localparam logic [CNT_W-1:0] HALF_V    = CNT_W'(SCLK_HALF);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(SCLK_HALF - 1);
    localparam logic [CNT_W-1:0] ONE_V     = CNT_W'(1);

    seq_state_t        state, state_nx;
    logic [CNT_W-1:0]  elapsed;
    logic [CNT_W:0]    elapsed_inc;
    logic [CNT_W-1:0]  span_q;
    logic              pd_q;
    logic              launch;
    logic [CNT_W-1:0]  rd_off, rd_phase;
    logic              read_high, cap_strobe;
    logic [DATA_W-1:0] cap_word;
    logic              cap_ok;

    assign elapsed_inc = {1'b0, elapsed} + (CNT_W+1)'(1);
    assign launch      = (state_nx == ST_HOLD) && (state != ST_HOLD);
    assign rd_off      = elapsed - READ_BASE;
    assign rd_phase    = rd_off / HALF_V;
    assign read_high   = (rd_phase & ONE_V) == '0;
    assign cap_strobe  = (state == ST_READ) && read_high && ((rd_off % HALF_V) == HALF_LAST);

    adc_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch),
        .elapsed (elapsed)
    );

    adc_serial_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_PDSAMPLE),
        .strobe   (cap_strobe),
        .sdata    (sdata),
        .frame_n  (frame_n),
        .word     (cap_word),
        .frame_ok (cap_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start || continuous)    state_nx = ST_HOLD;
            ST_HOLD:     if (elapsed == LOW_END)     state_nx = ST_CONVERT;
            ST_CONVERT:  if (elapsed == CONV_END)    state_nx = ST_PDSAMPLE;
            ST_PDSAMPLE: if (elapsed == PDS_END)     state_nx = ST_READ;
            ST_READ:     if (elapsed == READ_END)    state_nx = ST_ACQUIRE;
            ST_ACQUIRE:  if (elapsed_inc >= {1'b0, span_q})
                             state_nx = continuous ? ST_HOLD : ST_IDLE;
            default:                                 state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cnv_n = 1'b1;
        sclk  = 1'b0;
        unique case (state)
            ST_IDLE:     cnv_n = 1'b1;
            ST_HOLD:     cnv_n = 1'b0;
            ST_CONVERT:  cnv_n = ~pd_q;
            ST_PDSAMPLE: cnv_n = ~pd_q;
            ST_READ:     sclk  = read_high;
            ST_ACQUIRE:  cnv_n = 1'b1;
            default:     cnv_n = 1'b1;
        endcase
    end

    // per-conversion settings and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q         <= 1'b0;
            span_q       <= SPAN_MIN;
            result_valid <= 1'b0;
            result_data  <= '0;
        end else begin
            if (launch) begin
                pd_q   <= power_down_req;
                span_q <= (period_cycles > SPAN_MIN) ? period_cycles : SPAN_MIN;
            end
            result_valid <= 1'b0;
            if (state == ST_READ && state_nx == ST_ACQUIRE && cap_ok) begin
                result_valid <= 1'b1;
                result_data  <= cap_word;
            end
        end
    end
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
    parameter int CONV_CYC  = 42,
    parameter int PDS_CYC   = 10,
    parameter int VALID_AT  = 68,
    parameter int MIN_SPACE = 62
) (
    input logic clk,
    input logic rst_n,
    input logic cnv_n,
    input logic sclk,
    input logic power_down_req,
    input logic result_valid
);
    logic [15:0] cnt;
    logic        prev_cnv, prev_pd, pd_cap, seen;
    logic        fell_now;

    assign fell_now = prev_cnv && !cnv_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            prev_cnv <= 1'b1;
            prev_pd  <= 1'b0;
            pd_cap   <= 1'b0;
            seen     <= 1'b0;
        end else begin
            prev_cnv <= cnv_n;
            prev_pd  <= power_down_req;
            if (fell_now) begin
                cnt    <= 16'd1;
                seen   <= 1'b1;
                pd_cap <= prev_pd;
            end else if (cnt != 16'hFFFF) begin
                cnt <= cnt + 16'd1;
            end
        end
    end

    assert_sclk_after_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (seen && !fell_now && cnt >= 16'(CONV_CYC)));

    assert_pd_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !fell_now && cnt >= 16'(CONV_CYC) && cnt < 16'(CONV_CYC + PDS_CYC))
        |-> (cnv_n == !pd_cap));

    assert_wake_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !fell_now && cnt >= 16'(CONV_CYC + PDS_CYC)) |-> cnv_n);

    assert_valid_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (seen && cnt == 16'(VALID_AT)));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fell_now && seen) |-> (cnt >= 16'(MIN_SPACE)));
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(
    .CONV_CYC  (CONV_CYC),
    .PDS_CYC   (PDS_CYC),
    .VALID_AT  (READ_START + READ_CYC),
    .MIN_SPACE (ACQ_SPAN)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cnv_n          (cnv_n),
    .sclk           (sclk),
    .power_down_req (power_down_req),
    .result_valid   (result_valid)
);

// File: tb/sim_adc_conv_ctrl.sv
module sim_adc_conv_ctrl;
    localparam int CONV     = 42;
    localparam int PDS      = 10;
    localparam int LOW      = 2;
    localparam int RD_START = CONV + PDS;
    localparam int VAL_AT   = RD_START + 16;
    localparam int MIN_SP   = VAL_AT + 1;

    logic        clk = 1'b0;
    logic        rst_n, start, continuous, power_down_req;
    logic [15:0] period_cycles;
    logic        cnv_n, sclk, sdata, frame_n, result_valid;
    logic [7:0]  result_data;

    always #5 clk = ~clk;

    adc_conv_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .continuous(continuous),
        .power_down_req(power_down_req), .period_cycles(period_cycles),
        .cnv_n(cnv_n), .sclk(sclk), .sdata(sdata), .frame_n(frame_n),
        .result_valid(result_valid), .result_data(result_data)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // converter model: new word per falling edge, bits launched on sclk rise
    logic [7:0] cur_word = 8'h00;
    bit         cur_fe = 1'b0;
    bit         inj_fe = 1'b0;
    int         wseq = 0;

    initial begin
        sdata   = 1'b0;
        frame_n = 1'b1;
        forever begin
            @(negedge cnv_n);
            cur_word = 8'((wseq * 37 + 11) % 256);
            wseq++;
            cur_fe = inj_fe;
            for (int i = 7; i >= 0; i--) begin
                @(posedge sclk);
                #1;
                frame_n = cur_fe;
                sdata   = cur_word[i];
            end
            @(negedge sclk);
            #1;
            frame_n = 1'b1;
            sdata   = 1'b0;
        end
    end

    // monitor: cycle position within each conversion, sampled mid-cycle
    int         el = 0;
    bit         act = 1'b0;
    int         falls = 0;
    int         valids = 0;
    bit         pd_prev = 1'b0, pd_conv = 1'b0;
    bit         prev_cnv = 1'b1, prev_sclk = 1'b0;
    int         rises = 0, first_rise = -1;
    bit         early = 1'b0, wake_bad = 1'b0;
    logic [7:0] last_good = 8'h00;
    bit         chk_sp = 1'b0;
    int         exp_sp = MIN_SP;

    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            bit fall;
            fall = prev_cnv && !cnv_n;
            if (act) el++;
            if (act) begin
                if (sclk && !prev_sclk) begin
                    rises++;
                    if (first_rise < 0) first_rise = el;
                end
                if (sclk && el < CONV) early = 1'b1;
                if (el >= RD_START && !fall && !cnv_n) wake_bad = 1'b1;
                if (el == LOW - 1) check(cnv_n == 1'b0, "R2 pulse low", cnv_n, 0);
                if (el == LOW) check(cnv_n == !pd_conv, "R4 level after pulse", cnv_n, !pd_conv);
                if (el == CONV) check(!early, "R3 sclk during conversion", early, 0);
                if (el == CONV + PDS - 1)
                    check(cnv_n == !pd_conv, "R4 level at sample point", cnv_n, !pd_conv);
                if (el == RD_START) check(cnv_n == 1'b1, "R5 wake level", cnv_n, 1);
                if (el == VAL_AT) begin
                    check(rises == 8 && first_rise == RD_START, "R6 burst count*1000+first",
                          rises * 1000 + first_rise, 8 * 1000 + RD_START);
                    if (cur_fe) begin
                        check(result_valid == 1'b0, "R8 no valid on frame error", result_valid, 0);
                        check(result_data == last_good, "R8 data kept", result_data, last_good);
                    end else begin
                        check(result_valid == 1'b1, "R7 valid at cycle 68", result_valid, 1);
                        check(result_data == cur_word, "R7 R6 data msb first", result_data, cur_word);
                        last_good = cur_word;
                    end
                end
                if (el == VAL_AT + 1) check(result_valid == 1'b0, "R7 single pulse", result_valid, 0);
            end
            if (result_valid) valids++;
            if (fall) begin
                if (act) check(!wake_bad, "R5 high until next edge", wake_bad, 0);
                if (chk_sp && act) check(el == exp_sp, "R10 spacing", el, exp_sp);
                act = 1'b1;
                el = 0;
                falls++;
                pd_conv = pd_prev;
                rises = 0;
                first_rise = -1;
                early = 1'b0;
                wake_bad = 1'b0;
            end
            pd_prev   = power_down_req;
            prev_cnv  = cnv_n;
            prev_sclk = sclk;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_falls(input int n);
        int target;
        target = falls + n;
        while (falls < target) @(posedge clk);
        #2;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int f0, v0;
        rst_n = 1'b0;
        start = 1'b0;
        continuous = 1'b0;
        power_down_req = 1'b0;
        period_cycles = 16'd0;
        tick(3);
        check(cnv_n === 1'b1, "R1 reset cnv_n", cnv_n, 1);
        check(sclk === 1'b0, "R1 reset sclk", sclk, 0);
        check(result_valid === 1'b0, "R1 reset valid", result_valid, 0);
        rst_n = 1'b1;
        tick(5);
        check(cnv_n === 1'b1 && sclk === 1'b0, "R1 idle outputs", cnv_n, 1);

        // single conversion, stay awake; a second start while busy is ignored
        f0 = falls; v0 = valids;
        pulse_start();
        @(negedge clk);
        check(cnv_n == 1'b0, "R2 start to falling edge", cnv_n, 0);
        tick(20);
        pulse_start();
        tick(200);
        check(falls == f0 + 1, "R9 extra start ignored", falls - f0, 1);
        check(valids == v0 + 1, "R9 one result", valids - v0, 1);

        // single conversion with power-down
        power_down_req = 1'b1;
        f0 = falls;
        pulse_start();
        tick(150);
        power_down_req = 1'b0;
        check(falls == f0 + 1, "R4 power-down conversion ran", falls - f0, 1);

        // frame error, then a clean conversion
        inj_fe = 1'b1;
        v0 = valids;
        pulse_start();
        tick(150);
        inj_fe = 1'b0;
        check(valids == v0, "R8 dropped word", valids - v0, 0);
        pulse_start();
        tick(150);
        check(valids == v0 + 1, "R8 recovery", valids - v0, 1);

        // continuous spacing sweep
        continuous = 1'b1;
        foreach (period_list[k]) begin
            period_cycles = 16'(period_list[k]);
            wait_falls(2);
            exp_sp = (period_list[k] > MIN_SP) ? period_list[k] : MIN_SP;
            chk_sp = 1'b1;
            wait_falls(3);
            chk_sp = 1'b0;
        end

        // all 256 words back to back, power choice alternating
        period_cycles = 16'd0;
        wait_falls(1);
        exp_sp = MIN_SP;
        chk_sp = 1'b1;
        for (int n = 0; n < 256; n++) begin
            wait_falls(1);
            power_down_req = ~power_down_req;
        end
        chk_sp = 1'b0;

        // leave continuous mode mid-conversion
        wait_falls(1);
        continuous = 1'b0;
        power_down_req = 1'b0;
        f0 = falls; v0 = valids;
        tick(300);
        check(falls == f0, "R11 no new conversion", falls - f0, 0);
        check(valids == v0 + 1, "R11 last result delivered", valids - v0, 1);
        check(cnv_n == 1'b1, "R11 idle level", cnv_n, 1);

        finish_run();
    end

    int period_list [6] = '{0, 50, 69, 70, 100, 137};
endmodule